// File: doc/BRIEF.md
# Receive Character Queue with Per-Character Error Tags

This block buffers received characters between a serial receiver's shift stage and a byte-wide host read port. Each stored entry keeps its data byte together with three error tags: break, framing and parity. The tags only become visible to status logic when their character is at the head of the queue. Host software can therefore tell exactly which character was corrupted.

Alongside the data path, the block produces several flags: data available, threshold reached, idle timeout, overrun, and a sticky summary of errors. It supports two ways to empty the queue: a one-cycle flush strobe, or taking the enable low. It also applies a special rule when a break is received: only one zero character is loaded, and further loading is suppressed until the line has gone idle (mark) and a fresh start bit is detected. Serial deserialisation, baud generation and host address decode live in neighbouring blocks.

Top module: `rxq_buffer`

## Requirements
- R1: The queue holds up to DEPTH (default 16) characters in arrival order. `rd_data` shows the head character's byte while the queue is non-empty and reads 0 while it is empty. A `rd_stb` pulse removes the head entry. A `rd_stb` pulse on an empty queue changes nothing.
- R2: While `fifo_on` is low, every stored character is discarded on the next clock edge and incoming characters are ignored.
- R3: A one-cycle `flush` pulse empties the queue on the next edge. Any character or read presented in the same cycle is dropped.
- R4: `trig_hit` is high exactly while the stored count is at least the level chosen by `trig_sel`. The encodings are: 0 selects 1, 1 selects DEPTH/4, 2 selects DEPTH/2, and 3 selects DEPTH-2. With the default depth these are 1, 4, 8 and 14.
- R5: `tmo_flag` is high when the queue is non-empty and TMO_CHARS (default 4) `char_tick` pulses have occurred with no accepted write and no read. Any accepted write or read restarts the count.
- R6: `head_brk`, `head_frm` and `head_par` show the tags stored with the head character. They are 0 while the queue is empty.
- R7: A character offered while DEPTH entries are stored sets `ovr_flag` on the next edge and is discarded, leaving the contents unchanged. `ovr_flag` clears after an `lsr_rd` pulse, unless a new overrun occurs in the same cycle.
- R8: An accepted character with `char_brk` set is stored with data 0x00. After that, characters are ignored until `line_mark` has been seen high and a later `start_det` pulse arrives. The first character after that `start_det` pulse is accepted.
- R9: `err_any` sets on the edge after a character carrying any error tag is accepted. It clears after an `lsr_rd` pulse, unless such a character is accepted in the same cycle.
- R10: `data_rdy` is high exactly while at least one character is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_on | input | 1 | Queue enable; low discards contents |
| flush | input | 1 | One-cycle queue clear strobe |
| trig_sel | input | 2 | Threshold level select |
| char_vld | input | 1 | Received character strobe |
| char_data | input | 8 | Received character byte |
| char_brk | input | 1 | Received character is a break |
| char_frm | input | 1 | Received character has a framing error |
| char_par | input | 1 | Received character has a parity error |
| line_mark | input | 1 | Receive line currently at mark level |
| start_det | input | 1 | Valid start bit detected (pulse) |
| char_tick | input | 1 | One pulse per character time |
| rd_stb | input | 1 | Host read of head character |
| lsr_rd | input | 1 | Host read of line status |
| rd_data | output | 8 | Head character byte |
| head_brk | output | 1 | Head entry break tag |
| head_frm | output | 1 | Head entry framing tag |
| head_par | output | 1 | Head entry parity tag |
| data_rdy | output | 1 | Queue non-empty |
| trig_hit | output | 1 | Count at or above threshold |
| tmo_flag | output | 1 | Idle timeout with data stored |
| ovr_flag | output | 1 | Sticky overrun |
| err_any | output | 1 | Sticky summary of error-tagged arrivals |

## Verification
The bench builds the block with its defaults: depth 16 and a timeout of four character times. With these values a full queue and an overrun take only seventeen writes. Every threshold encoding can be stepped through during a single fill and drain. The timeout fires after a short run of ticks. Pointer wrap-around is covered because the queue is filled, drained and refilled, so entries pass the last storage slot while the error tags and the break hold are checked.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int unsigned DATA_W = 8;

  typedef struct packed {
    logic              brk;
    logic              frm;
    logic              par;
    logic [DATA_W-1:0] data;
  } rxq_ent_t;

  // threshold chosen by the 2-bit select, scaled from the queue depth
  function automatic int unsigned trig_level(input logic [1:0] sel,
                                             input int unsigned depth);
    case (sel)
      2'd0:    return 1;
      2'd1:    return depth / 4;
      2'd2:    return depth / 2;
      default: return depth - 2;
    endcase
  endfunction
endpackage

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push,
  input  rxq_ent_t         push_ent,
  input  logic             pop,
  output rxq_ent_t         head_ent,
  output logic [CNT_W-1:0] occ
);
  rxq_ent_t         mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push && !clr) mem[wr_ptr] <= push_ent;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
    end else begin
      if (push) wr_ptr <= ptr_next(wr_ptr);
      if (pop)  rd_ptr <= ptr_next(rd_ptr);
      occ <= occ + CNT_W'(push) - CNT_W'(pop);
    end
  end

  assign head_ent = (occ != '0) ? mem[rd_ptr] : '0;
endmodule

// File: rtl/rxq_break_gate.sv
module rxq_break_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic brk_stored,
  input  logic line_mark,
  input  logic start_det,
  output logic blocked
);
  logic mark_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blocked   <= 1'b0;
      mark_seen <= 1'b0;
    end else if (brk_stored) begin
      blocked   <= 1'b1;
      mark_seen <= 1'b0;
    end else if (blocked) begin
      if (mark_seen && start_det) begin
        blocked   <= 1'b0;
        mark_seen <= 1'b0;
      end else if (line_mark) begin
        mark_seen <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/rxq_idle_timer.sv
module rxq_idle_timer #(
  parameter int unsigned TMO_CHARS = 4,
  localparam int unsigned TW = $clog2(TMO_CHARS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic tick,
  output logic expired
);
  logic [TW-1:0] idle_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                    idle_cnt <= '0;
    else if (restart)                              idle_cnt <= '0;
    else if (tick && idle_cnt != TW'(TMO_CHARS))   idle_cnt <= idle_cnt + 1'b1;
  end

  assign expired = (idle_cnt == TW'(TMO_CHARS));
endmodule

// File: rtl/rxq_buffer.sv
module rxq_buffer
  import rxq_pkg::*;
#(
  parameter int unsigned DEPTH     = 16,
  parameter int unsigned TMO_CHARS = 4,
  localparam int unsigned CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_on,
  input  logic              flush,
  input  logic [1:0]        trig_sel,
  input  logic              char_vld,
  input  logic [DATA_W-1:0] char_data,
  input  logic              char_brk,
  input  logic              char_frm,
  input  logic              char_par,
  input  logic              line_mark,
  input  logic              start_det,
  input  logic              char_tick,
  input  logic              rd_stb,
  input  logic              lsr_rd,
  output logic [DATA_W-1:0] rd_data,
  output logic              head_brk,
  output logic              head_frm,
  output logic              head_par,
  output logic              data_rdy,
  output logic              trig_hit,
  output logic              tmo_flag,
  output logic              ovr_flag,
  output logic              err_any
);
  // named internal events, also observed by the checker
  logic             clr_evt, live, blocked, offer_evt, full;
  logic             acc_evt, ovr_evt, pop_evt, wr_err_evt, tmo_raw;
  logic [CNT_W-1:0] occ;
  rxq_ent_t         head_ent, new_ent;

  assign clr_evt    = !fifo_on || flush;
  assign live       = !clr_evt;
  assign full       = (occ == CNT_W'(DEPTH));
  assign offer_evt  = char_vld && live && !blocked;
  assign acc_evt    = offer_evt && !full;
  assign ovr_evt    = offer_evt && full;
  assign pop_evt    = rd_stb && live && (occ != '0);
  assign wr_err_evt = acc_evt && (char_brk || char_frm || char_par);

  always_comb begin
    new_ent.brk  = char_brk;
    new_ent.frm  = char_frm;
    new_ent.par  = char_par;
    new_ent.data = char_brk ? '0 : char_data;
  end

  rxq_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .clr(clr_evt), .push(acc_evt),
    .push_ent(new_ent), .pop(pop_evt), .head_ent(head_ent), .occ(occ)
  );

  rxq_break_gate u_gate (
    .clk(clk), .rst_n(rst_n), .brk_stored(acc_evt && char_brk),
    .line_mark(line_mark), .start_det(start_det), .blocked(blocked)
  );

  rxq_idle_timer #(.TMO_CHARS(TMO_CHARS)) u_timer (
    .clk(clk), .rst_n(rst_n),
    .restart(clr_evt || acc_evt || pop_evt || occ == '0),
    .tick(char_tick), .expired(tmo_raw)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_flag <= 1'b0;
      err_any  <= 1'b0;
    end else begin
      if (ovr_evt)         ovr_flag <= 1'b1;
      else if (lsr_rd)     ovr_flag <= 1'b0;
      if (wr_err_evt)      err_any  <= 1'b1;
      else if (lsr_rd)     err_any  <= 1'b0;
    end
  end

  assign rd_data  = head_ent.data;
  assign head_brk = head_ent.brk;
  assign head_frm = head_ent.frm;
  assign head_par = head_ent.par;
  assign data_rdy = (occ != '0);
  assign trig_hit = (occ >= CNT_W'(trig_level(trig_sel, DEPTH)));
  assign tmo_flag = tmo_raw && data_rdy;
endmodule

// File: rtl/rxq_buffer_chk.sv
module rxq_buffer_chk #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fifo_on,
  input logic             flush,
  input logic             char_vld,
  input logic             rd_stb,
  input logic             lsr_rd,
  input logic             blocked,
  input logic             wr_err_evt,
  input logic [CNT_W-1:0] occ,
  input logic [7:0]       rd_data,
  input logic             data_rdy,
  input logic             trig_hit,
  input logic             tmo_flag,
  input logic             ovr_flag,
  input logic             err_any
);
  p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CNT_W'(DEPTH));

  p_empty_reads_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !data_rdy |-> rd_data == 8'h00);

  p_disable_empties_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_on |=> !data_rdy);

  p_flush_empties_r3: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !data_rdy);

  p_trig_needs_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
    trig_hit |-> data_rdy);

  p_tmo_needs_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_flag |-> data_rdy);

  p_overrun_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (char_vld && fifo_on && !flush && !blocked && occ == CNT_W'(DEPTH))
      |=> ovr_flag && occ == CNT_W'(DEPTH) - CNT_W'($past(rd_stb)));

  p_break_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (blocked && char_vld && !rd_stb && fifo_on && !flush) |=> $stable(occ));

  p_err_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_rd && !wr_err_evt) |=> !err_any);
endmodule

bind rxq_buffer rxq_buffer_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fifo_on(fifo_on), .flush(flush),
  .char_vld(char_vld), .rd_stb(rd_stb), .lsr_rd(lsr_rd),
  .blocked(blocked), .wr_err_evt(wr_err_evt), .occ(occ),
  .rd_data(rd_data), .data_rdy(data_rdy), .trig_hit(trig_hit),
  .tmo_flag(tmo_flag), .ovr_flag(ovr_flag), .err_any(err_any)
);

// File: tb/tb_rxq_buffer.sv
module tb_rxq_buffer;
  localparam int DEPTH = 16;
  localparam int TMO   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fifo_on = 1'b0, flush = 1'b0, char_vld = 1'b0;
  logic [1:0] trig_sel = 2'd0;
  logic [7:0] char_data = 8'h00;
  logic char_brk = 1'b0, char_frm = 1'b0, char_par = 1'b0;
  logic line_mark = 1'b0, start_det = 1'b0, char_tick = 1'b0;
  logic rd_stb = 1'b0, lsr_rd = 1'b0;
  logic [7:0] rd_data;
  logic head_brk, head_frm, head_par, data_rdy, trig_hit, tmo_flag, ovr_flag, err_any;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  rxq_buffer dut (
    .clk(clk), .rst_n(rst_n), .fifo_on(fifo_on), .flush(flush), .trig_sel(trig_sel),
    .char_vld(char_vld), .char_data(char_data), .char_brk(char_brk),
    .char_frm(char_frm), .char_par(char_par), .line_mark(line_mark),
    .start_det(start_det), .char_tick(char_tick), .rd_stb(rd_stb), .lsr_rd(lsr_rd),
    .rd_data(rd_data), .head_brk(head_brk), .head_frm(head_frm), .head_par(head_par),
    .data_rdy(data_rdy), .trig_hit(trig_hit), .tmo_flag(tmo_flag),
    .ovr_flag(ovr_flag), .err_any(err_any)
  );

  // behavioural reference: entry = {brk, frm, par, data}
  logic [10:0] mq[$];
  bit m_blk, m_mark, m_ovr, m_err;
  int m_idle;

  always @(posedge clk) begin
    if (!rst_n) begin
      mq.delete(); m_blk = 0; m_mark = 0; m_ovr = 0; m_err = 0; m_idle = 0;
    end else begin
      bit en, offer, acc, popd, was_empty, brk_in;
      en = fifo_on && !flush;
      was_empty = (mq.size() == 0);
      offer = char_vld && en && !m_blk;
      acc = offer && mq.size() < DEPTH;
      popd = rd_stb && en && !was_empty;
      brk_in = acc && char_brk;
      if (!en) mq.delete();
      else begin
        if (popd) void'(mq.pop_front());
        if (acc) mq.push_back({char_brk, char_frm, char_par, char_brk ? 8'h00 : char_data});
      end
      if (offer && !acc) m_ovr = 1; else if (lsr_rd) m_ovr = 0;
      if (acc && (char_brk || char_frm || char_par)) m_err = 1; else if (lsr_rd) m_err = 0;
      if (!en || acc || popd || was_empty) m_idle = 0;
      else if (char_tick && m_idle < TMO) m_idle++;
      if (brk_in) begin m_blk = 1; m_mark = 0; end
      else if (m_blk) begin
        if (m_mark && start_det) begin m_blk = 0; m_mark = 0; end
        else if (line_mark) m_mark = 1;
      end
    end
  end

  function automatic int lvl(input logic [1:0] s);
    case (s) 2'd0: return 1; 2'd1: return 4; 2'd2: return 8; default: return 14; endcase
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    logic [10:0] h;
    h = (mq.size() > 0) ? mq[0] : 11'h0;
    chk("R1", "rd_data", int'(rd_data), int'(h[7:0]));
    chk("R6", "tags", int'({head_brk, head_frm, head_par}), int'(h[10:8]));
    chk("R10", "data_rdy", int'(data_rdy), int'(mq.size() > 0));
    chk("R4", "trig_hit", int'(trig_hit), int'(mq.size() >= lvl(trig_sel)));
    chk("R5", "tmo_flag", int'(tmo_flag), int'(m_idle == TMO && mq.size() > 0));
    chk("R7", "ovr_flag", int'(ovr_flag), int'(m_ovr));
    chk("R9", "err_any", int'(err_any), int'(m_err));
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    compare_all();
    char_vld = 0; flush = 0; start_det = 0; char_tick = 0; rd_stb = 0; lsr_rd = 0;
    char_brk = 0; char_frm = 0; char_par = 0;
  endtask

  task automatic wr(input logic [7:0] d, input logic b, input logic f, input logic p);
    char_vld = 1; char_data = d; char_brk = b; char_frm = f; char_par = p;
    cyc();
  endtask

  task automatic rd();
    rd_stb = 1; cyc();
  endtask

  initial begin
    int wd = 0;
    while (!done && wd < 20000) begin @(posedge clk); wd++; end
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk); cyc(); cyc();
    rst_n = 1; fifo_on = 1;
    cyc();
    chk("R10", "reset empty", int'(data_rdy), 0);

    // R1 R10: ordering with several patterns
    wr(8'h11, 0, 0, 0); wr(8'hA5, 0, 0, 0); wr(8'h3C, 0, 0, 0);
    chk("R1", "head is first", int'(rd_data), 'h11);
    rd(); chk("R1", "second byte", int'(rd_data), 'hA5);
    rd(); rd();
    rd(); chk("R1", "empty read", int'(rd_data), 0);

    // R4 R7: fill to full while sweeping threshold select, then overrun
    for (int i = 0; i < DEPTH; i++) begin
      trig_sel = 2'(i % 4);
      wr(8'(8'h40 + i), 0, 0, 0);
    end
    for (int s = 0; s < 4; s++) begin trig_sel = 2'(s); cyc(); end
    wr(8'hEE, 0, 0, 0);
    chk("R7", "overrun set", int'(ovr_flag), 1);
    chk("R7", "head kept", int'(rd_data), 'h40);
    lsr_rd = 1; cyc();
    chk("R7", "overrun cleared", int'(ovr_flag), 0);
    for (int i = 0; i < DEPTH; i++) begin trig_sel = 2'(i % 4); rd(); end
    chk("R7", "discarded char absent", int'(data_rdy), 0);

    // R5: idle timeout and clear by read
    wr(8'h5A, 0, 0, 0); wr(8'h5B, 0, 0, 0);
    for (int t = 0; t < TMO + 1; t++) begin char_tick = 1; cyc(); end
    chk("R5", "timeout set", int'(tmo_flag), 1);
    rd(); chk("R5", "timeout cleared by read", int'(tmo_flag), 0);
    for (int t = 0; t < TMO - 1; t++) begin char_tick = 1; cyc(); end
    chk("R5", "not yet", int'(tmo_flag), 0);
    rd();

    // R6 R9: tags follow characters to the head
    wr(8'h01, 0, 0, 0); wr(8'h02, 0, 0, 1); wr(8'h03, 0, 1, 0);
    chk("R9", "summary set", int'(err_any), 1);
    chk("R6", "clean head", int'(head_par), 0);
    rd(); chk("R6", "parity head", int'(head_par), 1);
    rd(); chk("R6", "framing head", int'(head_frm), 1);
    lsr_rd = 1; cyc();
    chk("R9", "summary cleared", int'(err_any), 0);
    rd();

    // R8: break loads one zero, blocks, released by mark then start
    wr(8'hAB, 1, 1, 0);
    chk("R8", "zero stored", int'(rd_data), 0);
    wr(8'h77, 0, 0, 0); wr(8'h78, 1, 0, 0);
    start_det = 1; cyc();
    wr(8'h79, 0, 0, 0);
    line_mark = 1; cyc(); line_mark = 0;
    wr(8'h7A, 0, 0, 0);
    start_det = 1; cyc();
    wr(8'h7B, 0, 0, 0);
    rd(); chk("R8", "first after release", int'(rd_data), 'h7B);
    rd();
    lsr_rd = 1; cyc();

    // R3: flush mid-stream, same-cycle write dropped
    wr(8'h21, 0, 0, 0); wr(8'h22, 0, 0, 0);
    flush = 1; char_vld = 1; char_data = 8'h23; cyc();
    chk("R3", "flushed", int'(data_rdy), 0);
    wr(8'h24, 0, 0, 0);
    chk("R3", "refill after flush", int'(rd_data), 'h24);

    // R2: disable discards and ignores
    fifo_on = 0; cyc();
    chk("R2", "disabled empty", int'(data_rdy), 0);
    wr(8'h55, 0, 0, 0);
    chk("R2", "ignored while off", int'(data_rdy), 0);
    fifo_on = 1; wr(8'h56, 0, 0, 0);
    chk("R2", "back on", int'(rd_data), 'h56);
    rd(); cyc();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule